// File: doc/BRIEF.md
# Interrupt Context Save-Restore Engine

This block works next to one hardware thread's interrupt context registers. When software installs a virtual-processor context by writing the context word, the engine can fetch that processor's descriptor from memory. It restores the saved current-priority value and pending bits into the thread registers, then marks the descriptor as checked out by this thread. When software removes the context by reading the context word, the engine can validate the descriptor and store the live priority, pending bits and lowest-priority-seen byte back into it. It then checks the descriptor back in.

The automatic transfer happens only when a global enable input is set and the context itself carries a hardware-managed flag. An ownership check and a checkout check guard the transfer, and so does a comparison of the stored thread number. Descriptor memory is reached through a word-granular request/acknowledge port with one access outstanding at a time. Any guard that fails produces a one-cycle error pulse, and memory is left untouched.

Top module: `ctx_sr_engine`

## Requirements
- R1: The context word uses bit 31 as V (valid), bit 30 as H (hardware-managed) and bits 27:0 as the descriptor identifier. An accepted write (push) stores the word. An accepted read (pull) clears V and, from the next cycle, presents the word as it was before the pull on `ctx_rd_data`.
- R2: While V is set, H cannot change: a push applied to a context whose V is set keeps the stored H and ignores the written H.
- R3: No memory access takes place unless `sr_enable` is 1 and the H flag of the context is 1. For a push this is the effective H after R2; for a pull it is the stored H, and the stored V must also be 1.
- R4: A save first reads descriptor word 0 and word 1. It fails if word0 bit 31 (valid) is 0, if word0 bit 24 (hardware-owned) is 0, or if word1 bit 18 (checked out) is 0. A failure gives a one-cycle `err` pulse as `busy` falls, and nothing is written.
- R5: A save also fails when word1 bit 15 (thread-valid) is 1 and word1 bits 14:0 differ from `thread_id`. When bit 15 is 0, the stored number is not compared.
- R6: A successful save writes word 2 first and word 1 second. Word 2 receives CPPR in bits 31:24, pending bits in 23:16 and the lowest-priority-seen byte in 15:8, and its bits 7:0 are kept. Word 1 is written with bit 18 cleared and bits 14:0 set to all ones, and all its other bits are kept, including bit 15.
- R7: A restore needs word0 bits 31 and 24 both set; otherwise it pulses `err` and writes nothing. It writes word 2 with bits 31:16 cleared and bits 15:0 kept. It loads the saved bits 31:24 into CPPR and ORs the saved bits 23:16 into the pending register.
- R8: After word 2, a restore writes word 1. Bit 18 is set, bit 15 is set and bits 14:0 take `thread_id`. The privilege field in bits 17:16 is set to 0, where the codes are 0 for OS, 1 for pool and 2 for hard. All other bits are kept.
- R9: Pending bit p stands for priority p, and 0 is the most urgent. `irq` is 1 exactly when the most urgent pending priority is numerically below CPPR. It is 0 when no bit is pending.
- R10: `busy` rises in the cycle after an accepted command that needs memory and stays high until the last access is acknowledged. While `busy` is high, pushes, pulls and thread-register writes are ignored.
- R11: When a push and a pull are presented in the same cycle, only the push is performed.
- R12: Descriptor word k of identifier n lives at memory address {n[ID_W-1:0], k}, where k is 3 bits wide by default. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay steady until `mem_ack`.
- R13: When not busy, a thread-register write loads CPPR, the pending bits and the lowest-priority-seen byte, and these are visible on the outputs in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_enable | input | 1 | Global enable for automatic save and restore |
| thread_id | input | 15 | Number of this hardware thread |
| ctx_wr_en | input | 1 | Push: write the context word |
| ctx_wr_data | input | 32 | Context word to push |
| ctx_rd_en | input | 1 | Pull: read the context word and clear V |
| ctx_rd_data | output | 32 | Word as it stood before the last pull |
| ctx_word | output | 32 | Current context word |
| tr_wr_en | input | 1 | Write the thread registers |
| tr_wr_cppr | input | 8 | CPPR value to write |
| tr_wr_ipb | input | 8 | Pending bits to write |
| tr_wr_lsmfb | input | 8 | Lowest-priority-seen byte to write |
| cppr | output | 8 | Current CPPR |
| ipb | output | 8 | Current pending bits |
| lsmfb | output | 8 | Current lowest-priority-seen byte |
| irq | output | 1 | Interrupt request to the thread |
| busy | output | 1 | A save or restore is in progress |
| err | output | 1 | One-cycle pulse when a guard check fails |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 11 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |

## Verification
A push and a pull can reach the engine in the same cycle. So can a software thread-register write and the CPPR/pending load that a restore performs. The bench drives both enables together in one cycle and expects the new context word, with the pull's read-back value left unchanged. It also holds pull, push and thread-register writes asserted through a whole restore and expects none of them to take effect. A behavioural model predicts the context word on every clock, and it predicts the thread registers and `irq` on every idle clock. After each command the bench compares descriptor memory and the order of memory writes.

// File: rtl/ctx_sr_pkg.sv
package ctx_sr_pkg;
   // context word layout
   localparam int CTX_V  = 31;
   localparam int CTX_H  = 30;
   // descriptor word 0
   localparam int D0_VALID = 31;
   localparam int D0_HWOWN = 24;
   // descriptor word 1
   localparam int D1_CO      = 18;
   localparam int D1_PRIV_HI = 17;
   localparam int D1_PRIV_LO = 16;
   localparam int D1_TVALID  = 15;
   localparam int TID_W      = 15;
   // privilege code written on checkout: 0 OS, 1 pool, 2 hard
   localparam logic [1:0] PRIV_OS = 2'd0;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_WR2, ST_WR1
   } sr_state_e;

   typedef struct packed {
      logic [7:0] cppr;
      logic [7:0] ipb;
      logic [7:0] lsmfb;
   } tregs_t;
endpackage

// File: rtl/ctx_sr_ctxword.sv
module ctx_sr_ctxword
   import ctx_sr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        push_i,
   input  logic        pull_i,
   input  logic        busy_i,
   input  logic [31:0] wdata_i,
   output logic        h_next_o,
   output logic [31:0] word_o,
   output logic [31:0] rdata_o
);
   logic [31:0] word_q;
   logic [31:0] rd_q;

   // H is frozen while the stored context is valid
   assign h_next_o = word_q[CTX_V] ? word_q[CTX_H] : wdata_i[CTX_H];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         rd_q   <= '0;
      end else if (push_i) begin
         word_q <= {wdata_i[CTX_V], h_next_o, wdata_i[29:0]};
      end else if (pull_i) begin
         rd_q          <= word_q;
         word_q[CTX_V] <= 1'b0;
      end
   end

   assign word_o  = word_q;
   assign rdata_o = rd_q;

   p_h_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (word_q[CTX_V] && $past(word_q[CTX_V])) |-> (word_q[CTX_H] == $past(word_q[CTX_H])))
      else $error("H changed while V held");

   p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> $stable(word_q))
      else $error("context word changed while busy");
endmodule

// File: rtl/ctx_sr_tregs.sv
module ctx_sr_tregs
   import ctx_sr_pkg::*;
#(
   parameter int NPRIO   = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_i,
   input  tregs_t     wr_val_i,
   input  logic       load_i,
   input  logic [7:0] load_cppr_i,
   input  logic [7:0] load_ipb_i,
   output tregs_t     tregs_o,
   output logic       irq_o
);
   localparam int PW = $clog2(NPRIO) + 1;

   tregs_t        tregs_q;
   logic [PW-1:0] best;
   logic          irq_raw;

   initial assert (NPRIO == 8) else $error("pending field is 8 bits wide");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tregs_q <= '0;
      end else if (load_i) begin
         tregs_q.cppr <= load_cppr_i;
         tregs_q.ipb  <= tregs_q.ipb | load_ipb_i;
      end else if (wr_i) begin
         tregs_q <= wr_val_i;
      end
   end

   // most urgent pending priority = lowest set index
   always_comb begin
      best = PW'(NPRIO);
      for (int p = NPRIO - 1; p >= 0; p--) begin
         if (tregs_q.ipb[p]) best = PW'(p);
      end
   end

   assign irq_raw = (tregs_q.ipb != '0) && ({{(8 - PW){1'b0}}, best} < tregs_q.cppr);

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = irq_raw;
      end
   endgenerate

   assign tregs_o = tregs_q;

   p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tregs_q.ipb == '0) |-> !irq_raw)
      else $error("irq without pending bits");

   p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (tregs_q.cppr == $past(load_cppr_i)) &&
                 ((tregs_q.ipb & $past(load_ipb_i)) == $past(load_ipb_i)))
      else $error("restore load not applied");
endmodule

// File: rtl/ctx_sr_seq.sv
module ctx_sr_seq
   import ctx_sr_pkg::*;
#(
   parameter int ID_W   = 8,
   parameter int WIDX_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic                   save_i,
   input  logic [ID_W-1:0]        id_i,
   input  logic [TID_W-1:0]       tid_i,
   input  tregs_t                 live_i,
   output logic                   busy_o,
   output logic                   err_o,
   output logic                   load_o,
   output logic [7:0]             load_cppr_o,
   output logic [7:0]             load_ipb_o,
   output logic                   mem_req_o,
   output logic                   mem_we_o,
   output logic [ID_W+WIDX_W-1:0] mem_addr_o,
   output logic [31:0]            mem_wdata_o,
   input  logic                   mem_ack_i,
   input  logic [31:0]            mem_rdata_i
);
   sr_state_e          state;
   logic               save_q;
   logic [ID_W-1:0]    id_q;
   logic [TID_W-1:0]   tid_q;
   logic [31:0]        w1_q, w2_q;
   logic               err_q, load_q;
   logic [WIDX_W-1:0]  widx;
   logic               d0_ok, d1_bad;

   initial assert (WIDX_W >= 2) else $error("descriptor needs at least 3 words");

   assign d0_ok  = mem_rdata_i[D0_VALID] && mem_rdata_i[D0_HWOWN];
   assign d1_bad = !mem_rdata_i[D1_CO] ||
                   (mem_rdata_i[D1_TVALID] && (mem_rdata_i[TID_W-1:0] != tid_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         save_q <= 1'b0;
         id_q   <= '0;
         tid_q  <= '0;
         w1_q   <= '0;
         w2_q   <= '0;
         err_q  <= 1'b0;
         load_q <= 1'b0;
      end else begin
         err_q  <= 1'b0;
         load_q <= 1'b0;
         unique case (state)
            ST_IDLE: if (start_i) begin
               state  <= ST_RD0;
               save_q <= save_i;
               id_q   <= id_i;
               tid_q  <= tid_i;
            end
            ST_RD0: if (mem_ack_i) begin
               if (d0_ok) state <= ST_RD1;
               else begin
                  err_q <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            ST_RD1: if (mem_ack_i) begin
               w1_q <= mem_rdata_i;
               if (save_q && d1_bad) begin
                  err_q <= 1'b1;
                  state <= ST_IDLE;
               end else begin
                  state <= ST_RD2;
               end
            end
            ST_RD2: if (mem_ack_i) begin
               w2_q  <= mem_rdata_i;
               state <= ST_WR2;
            end
            ST_WR2: if (mem_ack_i) begin
               load_q <= !save_q;
               state  <= ST_WR1;
            end
            ST_WR1: if (mem_ack_i) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (state)
         ST_RD1, ST_WR1: widx = WIDX_W'(1);
         ST_RD2, ST_WR2: widx = WIDX_W'(2);
         default:        widx = '0;
      endcase
   end

   always_comb begin
      mem_wdata_o = '0;
      if (state == ST_WR2) begin
         if (save_q) mem_wdata_o = {live_i.cppr, live_i.ipb, live_i.lsmfb, w2_q[7:0]};
         else        mem_wdata_o = {16'h0000, w2_q[15:0]};
      end else if (state == ST_WR1) begin
         mem_wdata_o = w1_q;
         if (save_q) begin
            mem_wdata_o[D1_CO]       = 1'b0;
            mem_wdata_o[TID_W-1:0]   = '1;
         end else begin
            mem_wdata_o[D1_CO]       = 1'b1;
            mem_wdata_o[D1_PRIV_HI:D1_PRIV_LO] = PRIV_OS;
            mem_wdata_o[D1_TVALID]   = 1'b1;
            mem_wdata_o[TID_W-1:0]   = tid_q;
         end
      end
   end

   assign busy_o      = (state != ST_IDLE);
   assign mem_req_o   = busy_o;
   assign mem_we_o    = (state == ST_WR2) || (state == ST_WR1);
   assign mem_addr_o  = {id_q, widx};
   assign err_o       = err_q;
   assign load_o      = load_q;
   assign load_cppr_o = w2_q[31:24];
   assign load_ipb_o  = w2_q[23:16];

   p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                    $stable(mem_we_o) && $stable(mem_wdata_o)))
      else $error("request dropped or changed before ack");

   p_w1_after_w2_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_WR1) && ($past(state) != ST_WR1)) |-> ($past(state) == ST_WR2))
      else $error("word1 written without word2 first");

   p_err_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !busy_o ##1 !err_o)
      else $error("err not a single idle pulse");

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mem_req_o)
      else $error("memory request while idle");
endmodule

// File: rtl/ctx_sr_engine.sv
module ctx_sr_engine
   import ctx_sr_pkg::*;
#(
   parameter int ID_W    = 8,
   parameter int WIDX_W  = 3,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sr_enable,
   input  logic [TID_W-1:0]       thread_id,
   input  logic                   ctx_wr_en,
   input  logic [31:0]            ctx_wr_data,
   input  logic                   ctx_rd_en,
   output logic [31:0]            ctx_rd_data,
   output logic [31:0]            ctx_word,
   input  logic                   tr_wr_en,
   input  logic [7:0]             tr_wr_cppr,
   input  logic [7:0]             tr_wr_ipb,
   input  logic [7:0]             tr_wr_lsmfb,
   output logic [7:0]             cppr,
   output logic [7:0]             ipb,
   output logic [7:0]             lsmfb,
   output logic                   irq,
   output logic                   busy,
   output logic                   err,
   output logic                   mem_req,
   output logic                   mem_we,
   output logic [ID_W+WIDX_W-1:0] mem_addr,
   output logic [31:0]            mem_wdata,
   input  logic                   mem_ack,
   input  logic [31:0]            mem_rdata
);
   localparam int AW = ID_W + WIDX_W;

   initial assert (ID_W >= 1 && ID_W <= 28) else $error("ID_W out of range");

   logic        push_acc, pull_acc, h_next;
   logic        start_restore, start_save;
   logic [ID_W-1:0] start_id;
   logic        load;
   logic [7:0]  load_cppr, load_ipb;
   tregs_t      tregs, tr_wval;
   logic [AW-1:0] addr_w;

   // push wins over a pull in the same cycle
   assign push_acc = ctx_wr_en && !busy;
   assign pull_acc = ctx_rd_en && !ctx_wr_en && !busy;

   assign start_restore = push_acc && ctx_wr_data[CTX_V] && h_next && sr_enable;
   assign start_save    = pull_acc && ctx_word[CTX_V] && ctx_word[CTX_H] && sr_enable;
   assign start_id      = push_acc ? ctx_wr_data[ID_W-1:0] : ctx_word[ID_W-1:0];
   assign tr_wval       = '{cppr: tr_wr_cppr, ipb: tr_wr_ipb, lsmfb: tr_wr_lsmfb};

   ctx_sr_ctxword u_word (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_i   (push_acc),
      .pull_i   (pull_acc),
      .busy_i   (busy),
      .wdata_i  (ctx_wr_data),
      .h_next_o (h_next),
      .word_o   (ctx_word),
      .rdata_o  (ctx_rd_data)
   );

   ctx_sr_tregs #(.NPRIO(8), .IRQ_REG(IRQ_REG)) u_tregs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_i        (tr_wr_en && !busy),
      .wr_val_i    (tr_wval),
      .load_i      (load),
      .load_cppr_i (load_cppr),
      .load_ipb_i  (load_ipb),
      .tregs_o     (tregs),
      .irq_o       (irq)
   );

   ctx_sr_seq #(.ID_W(ID_W), .WIDX_W(WIDX_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_restore || start_save),
      .save_i      (start_save),
      .id_i        (start_id),
      .tid_i       (thread_id),
      .live_i      (tregs),
      .busy_o      (busy),
      .err_o       (err),
      .load_o      (load),
      .load_cppr_o (load_cppr),
      .load_ipb_o  (load_ipb),
      .mem_req_o   (mem_req),
      .mem_we_o    (mem_we),
      .mem_addr_o  (addr_w),
      .mem_wdata_o (mem_wdata),
      .mem_ack_i   (mem_ack),
      .mem_rdata_i (mem_rdata)
   );

   assign mem_addr = addr_w;
   assign cppr     = tregs.cppr;
   assign ipb      = tregs.ipb;
   assign lsmfb    = tregs.lsmfb;

   p_ack_only_on_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ack |-> mem_req)
      else $error("ack without request");
endmodule

// File: tb/ctx_sr_engine_test.sv
`timescale 1ns/1ps
module ctx_sr_engine_test;
   localparam int ID_W = 8;
   localparam int AW   = ID_W + 3;
   localparam logic [14:0] TID = 15'h1234;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sr_enable = 1'b0;
   logic ctx_wr_en = 1'b0, ctx_rd_en = 1'b0, tr_wr_en = 1'b0;
   logic [31:0] ctx_wr_data = '0;
   logic [7:0] tr_wr_cppr = '0, tr_wr_ipb = '0, tr_wr_lsmfb = '0;
   logic [31:0] ctx_rd_data, ctx_word, mem_wdata;
   logic [7:0] cppr, ipb, lsmfb;
   logic irq, busy, err, mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic mem_ack;
   logic [31:0] mem_rdata;

   always #2 clk = ~clk;

   ctx_sr_engine uut (
      .clk(clk), .rst_n(rst_n), .sr_enable(sr_enable), .thread_id(TID),
      .ctx_wr_en(ctx_wr_en), .ctx_wr_data(ctx_wr_data), .ctx_rd_en(ctx_rd_en),
      .ctx_rd_data(ctx_rd_data), .ctx_word(ctx_word),
      .tr_wr_en(tr_wr_en), .tr_wr_cppr(tr_wr_cppr), .tr_wr_ipb(tr_wr_ipb),
      .tr_wr_lsmfb(tr_wr_lsmfb), .cppr(cppr), .ipb(ipb), .lsmfb(lsmfb),
      .irq(irq), .busy(busy), .err(err), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata)
   );

   // memory responder with adjustable latency
   logic [31:0] mem [0:(1<<AW)-1];
   logic [AW-1:0] wlog [$];
   int lat = 0;
   int cnt = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0; mem_rdata <= '0; cnt <= 0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0; cnt <= 0;
      end else if (mem_req) begin
         if (cnt >= lat) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr];
            if (mem_we) begin
               mem[mem_addr] <= mem_wdata;
               wlog.push_back(mem_addr);
            end
         end else cnt <= cnt + 1;
      end
   end

   int checks = 0, errors = 0;
   bit finished = 1'b0;
   logic [31:0] m_word = '0, m_rd = '0;
   logic [7:0] m_cppr = '0, m_ipb = '0, m_lsmfb = '0;

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic exp_irq(input logic [7:0] c, input logic [7:0] i);
      for (int p = 0; p < 8; p++) if (i[p]) return (p < c);
      return 1'b0;
   endfunction

   // one clock; outputs sampled on the falling edge
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      chk("R1", "ctx_word", ctx_word, m_word);
      if (!busy) begin
         chk("R13", "cppr", {24'h0, cppr}, {24'h0, m_cppr});
         chk("R13", "ipb", {24'h0, ipb}, {24'h0, m_ipb});
         chk("R13", "lsmfb", {24'h0, lsmfb}, {24'h0, m_lsmfb});
         chk("R9", "irq", {31'h0, irq}, {31'h0, exp_irq(m_cppr, m_ipb)});
      end
   endtask

   task automatic twr(input logic [7:0] c, input logic [7:0] i, input logic [7:0] l);
      tr_wr_en = 1'b1; tr_wr_cppr = c; tr_wr_ipb = i; tr_wr_lsmfb = l;
      m_cppr = c; m_ipb = i; m_lsmfb = l;
      tick();
      tr_wr_en = 1'b0;
   endtask

   // push and/or pull with full prediction of memory effects
   task automatic cmd(input bit do_push, input bit do_pull, input logic [31:0] w,
                      input bit intrude, input string tag);
      logic h, act, fail, save;
      logic [ID_W-1:0] id;
      logic [AW-1:0] base;
      logic [31:0] d0, d1, d2, x1, x2;
      act = 1'b0; save = 1'b0; id = '0;
      if (do_push) begin
         h = m_word[31] ? m_word[30] : w[30];
         act = w[31] && h && sr_enable;
         id = w[ID_W-1:0];
         m_word = {w[31], h, w[29:0]};
      end else begin
         act = m_word[31] && m_word[30] && sr_enable;
         save = 1'b1;
         id = m_word[ID_W-1:0];
         m_rd = m_word;
         m_word[31] = 1'b0;
      end
      base = {id, 3'b000};
      d0 = mem[base]; d1 = mem[base + 1]; d2 = mem[base + 2];
      fail = !(d0[31] && d0[24]) ||
             (save && (!d1[18] || (d1[15] && d1[14:0] != TID)));
      x1 = d1; x2 = d2;
      if (act && !fail) begin
         if (save) begin
            x2 = {m_cppr, m_ipb, m_lsmfb, d2[7:0]};
            x1[18] = 1'b0; x1[14:0] = 15'h7fff;
         end else begin
            x2 = {16'h0, d2[15:0]};
            x1[18] = 1'b1; x1[17:16] = 2'd0; x1[15] = 1'b1; x1[14:0] = TID;
            m_cppr = d2[31:24]; m_ipb = m_ipb | d2[23:16];
         end
      end
      wlog.delete();
      ctx_wr_en = do_push; ctx_rd_en = do_pull; ctx_wr_data = w;
      tick();
      ctx_wr_en = 1'b0; ctx_rd_en = 1'b0;
      chk("R10", "busy after command", {31'h0, busy}, {31'h0, act});
      while (busy) begin
         if (intrude) begin
            ctx_rd_en = 1'b1; ctx_wr_en = 1'b1; ctx_wr_data = 32'h4000_00ee;
            tr_wr_en = 1'b1; tr_wr_cppr = 8'haa; tr_wr_ipb = 8'h55; tr_wr_lsmfb = 8'h77;
         end
         tick();
      end
      ctx_rd_en = 1'b0; ctx_wr_en = 1'b0; tr_wr_en = 1'b0;
      chk(tag, "err pulse", {31'h0, err}, {31'h0, act && fail});
      chk(save ? "R6" : "R8", "descriptor word1", mem[base + 1], x1);
      chk(save ? "R6" : "R7", "descriptor word2", mem[base + 2], x2);
      chk("R1", "read-back", ctx_rd_data, m_rd);
      chk("R12", "write count", wlog.size(), (act && !fail) ? 2 : 0);
      if (wlog.size() == 2) begin
         chk("R6", "first write addr", {21'h0, wlog[0]}, {21'h0, base + AW'(2)});
         chk("R6", "second write addr", {21'h0, wlog[1]}, {21'h0, base + AW'(1)});
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < (1 << AW); a++) mem[a] = '0;
      // descriptor 5: valid + hw owned, not checked out
      mem[40] = 32'h8100_0000; mem[41] = 32'h00a0_0000; mem[42] = 32'h0610_3355;
      // descriptor 9: valid but not hw owned
      mem[72] = 32'h8000_0000; mem[73] = 32'h0004_0000; mem[74] = 32'h0920_0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R1, R10)
      chk("R1", "reset ctx_word", ctx_word, 32'h0);
      chk("R10", "reset busy", {31'h0, busy}, 32'h0);
      chk("R12", "reset mem_req", {31'h0, mem_req}, 32'h0);
      chk("R9", "reset irq", {31'h0, irq}, 32'h0);

      twr(8'hff, 8'h00, 8'h00);                       // R13
      cmd(1, 0, 32'hc000_0005, 0, "R3");              // disabled: no memory (R3)
      cmd(0, 1, 32'h0, 0, "R3");                      // pull returns word, clears V (R1)
      // R2: H frozen while V set
      cmd(1, 0, 32'hc000_0007, 0, "R2");
      cmd(1, 0, 32'h8000_0007, 0, "R2");
      chk("R2", "H kept", {31'h0, ctx_word[30]}, 32'h1);
      cmd(0, 1, 32'h0, 0, "R2");
      cmd(1, 0, 32'h8000_0007, 0, "R2");
      chk("R2", "H cleared when V was 0", {31'h0, ctx_word[30]}, 32'h0);
      cmd(0, 1, 32'h0, 0, "R2");

      // restore descriptor 5 (R7, R8, R9)
      sr_enable = 1'b1;
      cmd(1, 0, 32'hc000_0005, 0, "R7");
      chk("R7", "cppr restored", {24'h0, cppr}, 32'h06);
      chk("R9", "irq prio 4 below 6", {31'h0, irq}, 32'h1);
      // R9 boundary: pending priority equals CPPR
      twr(8'h04, 8'h10, 8'h21);
      chk("R9", "irq equal prio", {31'h0, irq}, 32'h0);
      twr(8'h03, 8'h80, 8'h21);
      // save with matching thread (R6)
      lat = 2;
      cmd(0, 1, 32'h0, 0, "R6");
      // H=0 push with enable: no memory (R3)
      cmd(1, 0, 32'h8000_0005, 0, "R3");
      cmd(0, 1, 32'h0, 0, "R3");
      // save refused: not checked out (R4)
      sr_enable = 1'b0;
      cmd(1, 0, 32'hc000_0005, 0, "R4");
      sr_enable = 1'b1;
      cmd(0, 1, 32'h0, 0, "R4");
      // save refused: other thread holds it (R5)
      mem[41] = 32'h0004_8abc;
      sr_enable = 1'b0;
      cmd(1, 0, 32'hc000_0005, 0, "R5");
      sr_enable = 1'b1;
      cmd(0, 1, 32'h0, 0, "R5");
      // thread number not valid: save allowed (R5)
      mem[41] = 32'h0004_0abc;
      sr_enable = 1'b0;
      cmd(1, 0, 32'hc000_0005, 0, "R5");
      sr_enable = 1'b1;
      lat = 0;
      cmd(0, 1, 32'h0, 0, "R5");
      // restore refused: not hardware owned (R7)
      cmd(1, 0, 32'hc000_0009, 0, "R7");
      sr_enable = 1'b0;
      cmd(0, 1, 32'h0, 0, "R7");
      sr_enable = 1'b1;
      // commands ignored while busy (R10)
      lat = 3;
      cmd(1, 0, 32'hc000_0005, 1, "R10");
      lat = 0;
      sr_enable = 1'b0;
      cmd(0, 1, 32'h0, 0, "R10");
      // push and pull together: push only (R11)
      cmd(1, 0, 32'h8000_0003, 0, "R11");
      cmd(1, 1, 32'h8000_0011, 0, "R11");
      chk("R11", "pushed word", ctx_word, 32'h8000_0011);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule